// File: doc/BRIEF.md
# Write-Only Two-Wire Register Slave

This block is a slave that only receives on a two-wire serial bus (I2C style). It runs from a system clock that oversamples the bus. Both bus lines pass through a synchronizer and a glitch filter before anything looks at them. The block finds START and STOP conditions and clocks in a 7-bit device address plus a direction bit, most significant bit first. It acknowledges only when the address is its own and the direction is write. It then takes in exactly one 8-bit data word, acknowledges that word, and presents it on a parallel output together with a single-cycle valid strobe.

The slave never returns read data and never holds the clock low. It drives the data line only through an open-drain enable: asserting `sdaOe` pulls the line low. Each transfer is one START, one address byte, one data byte and one STOP. A START seen at any point, even part-way through a byte, restarts address reception. A STOP seen at any point sends the slave back to idle.

The system clock must run at ten times the fastest bus clock or faster. At the default filter length, a pulse on either line that lasts two system cycles or less is ignored.

Top module: `wo_i2c_slave`

## Requirements
- R1: While reset is asserted and right after it is released, `sdaOe` is 0, `dataValid` is 0 and `dataOut` is 8'h00.
- R2: Before the first START, bus clocking is ignored. A full byte clocked without a preceding START gets no acknowledge and no output update.
- R3: After a START, the first byte is taken MSB first on rising SCL edges as a 7-bit address followed by a direction bit. When the address equals `DEV_ADDR` (default 7'b1100000) and the direction bit is 0, the slave acknowledges.
- R4: If the direction bit is 1 (read) or the address differs, the slave never asserts `sdaOe` for that transfer and does not update `dataOut`.
- R5: `sdaOe` is asserted only during an acknowledge slot. It turns on at the SCL falling edge that follows the eighth bit of a byte and turns off at the next SCL falling edge. The data line is therefore held low for the whole high phase of the ninth clock.
- R6: After an acknowledged address, one data byte is taken MSB first and acknowledged. `dataOut` takes the byte, and `dataValid` pulses high for exactly one cycle at the same time as the acknowledge drive begins.
- R7: Further bytes after the acknowledged data byte, before a STOP, are not acknowledged and do not change `dataOut` or pulse `dataValid`.
- R8: A START at any point, including a repeated START in the middle of a byte, discards any partial byte and restarts address reception.
- R9: A STOP at any point returns the slave to idle and releases `sdaOe`. A partially received data byte does not reach `dataOut`.
- R10: A pulse on SCL that lasts no more than `FILT_LEN-1` system cycles (2 at the default) is not taken as a bus clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least ten times the bus clock rate |
| rstN | input | 1 | Active-low synchronous reset |
| sclIn | input | 1 | Bus clock line as seen on the pin |
| sdaIn | input | 1 | Bus data line as seen on the pin |
| sdaOe | output | 1 | Pull-down enable for the data line (1 pulls low) |
| dataOut | output | 8 | Last data word received |
| dataValid | output | 1 | One-cycle strobe when `dataOut` is updated |

## Verification
The hardest case to reach from the pins is a START arriving in the middle of an address byte, while the bit counter is partly filled. The stimulus clocks four address bits, raises SDA while SCL is low, and then produces a fresh START before sending a complete write. A STOP in the middle of the data byte is driven the same way. A two-cycle SCL spike is placed inside the low phase of a data bit. A reference model that follows the raw bus events predicts the acknowledge drive, and the drive is compared against it in every bus half-period once the lines have settled.

// File: rtl/wo_i2c_pkg.sv
package wo_i2c_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ACK_A,
    ST_DATA,
    ST_ACK_D,
    ST_SKIP
  } slvState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic shiftBit;
    logic clrCount;
    logic ackOn;
    logic ackOff;
    logic loadOut;
  } dpCmd_t;

  // events from datapath to control
  typedef struct packed {
    logic sclRise;
    logic sclFall;
    logic startDet;
    logic stopDet;
    logic byteFull;
    logic addrHit;
  } busEvt_t;

endpackage

// File: rtl/wo_i2c_filter.sv
module wo_i2c_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 3
) (
  input  logic clk,
  input  logic rstN,
  input  logic rawIn,
  output logic filtOut
);

  logic [SYNC_STAGES-1:0] syncQ;
  logic [FILT_LEN-1:0]    histQ;
  logic                   levelQ;

  // metastability chain, idles high like the bus
  always_ff @(posedge clk) begin
    if (!rstN) syncQ <= '1;
    else       syncQ <= {syncQ[SYNC_STAGES-2:0], rawIn};
  end

  // history of synchronized samples; output moves only on full agreement
  always_ff @(posedge clk) begin
    if (!rstN) begin
      histQ  <= '1;
      levelQ <= 1'b1;
    end else begin
      histQ <= {histQ[FILT_LEN-2:0], syncQ[SYNC_STAGES-1]};
      if (&histQ)       levelQ <= 1'b1;
      else if (~|histQ) levelQ <= 1'b0;
    end
  end

  assign filtOut = levelQ;

endmodule

// File: rtl/wo_i2c_datapath.sv
module wo_i2c_datapath
  import wo_i2c_pkg::*;
#(
  parameter int         ADDR_W      = 7,
  parameter int         WORD_W      = 8,
  parameter logic [6:0] DEV_ADDR    = 7'b1100000,
  parameter int         SYNC_STAGES = 2,
  parameter int         FILT_LEN    = 3,
  localparam int        CNT_W       = $clog2(WORD_W + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  dpCmd_t            cmd,
  output busEvt_t           evt,
  output logic              sdaOe,
  output logic [WORD_W-1:0] dataOut,
  output logic              dataValid,
  output logic [CNT_W-1:0]  bitCnt
);

  localparam int NUM_LINES = 2;

  logic [NUM_LINES-1:0] rawBus;
  logic [NUM_LINES-1:0] filtBus;
  logic                 sclF, sdaF, sclPrev, sdaPrev;
  logic [WORD_W-1:0]    shiftReg;
  logic                 ackQ;

  assign rawBus = {sdaIn, sclIn};

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    wo_i2c_filter #(
      .SYNC_STAGES(SYNC_STAGES),
      .FILT_LEN   (FILT_LEN)
    ) u_filt (
      .clk    (clk),
      .rstN   (rstN),
      .rawIn  (rawBus[g]),
      .filtOut(filtBus[g])
    );
  end

  assign sclF = filtBus[0];
  assign sdaF = filtBus[1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPrev <= sclF;
      sdaPrev <= sdaF;
    end
  end

  // bus events from the filtered lines
  always_comb begin
    evt.sclRise  = sclF & ~sclPrev;
    evt.sclFall  = ~sclF & sclPrev;
    evt.startDet = sclF & sclPrev & sdaPrev & ~sdaF;
    evt.stopDet  = sclF & sclPrev & ~sdaPrev & sdaF;
    evt.byteFull = (bitCnt == CNT_W'(WORD_W));
    evt.addrHit  = (shiftReg[WORD_W-1 -: ADDR_W] == DEV_ADDR[ADDR_W-1:0]) & ~shiftReg[0];
  end

  // bit shifter and counter
  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg <= '0;
      bitCnt   <= '0;
    end else if (cmd.clrCount) begin
      bitCnt <= '0;
    end else if (cmd.shiftBit) begin
      shiftReg <= {shiftReg[WORD_W-2:0], sdaF};
      bitCnt   <= bitCnt + 1'b1;
    end
  end

  // open-drain acknowledge drive
  always_ff @(posedge clk) begin
    if (!rstN)            ackQ <= 1'b0;
    else if (cmd.ackOff)  ackQ <= 1'b0;
    else if (cmd.ackOn)   ackQ <= 1'b1;
  end
  assign sdaOe = ackQ;

  // parallel word output
  always_ff @(posedge clk) begin
    if (!rstN) begin
      dataOut   <= '0;
      dataValid <= 1'b0;
    end else begin
      dataValid <= cmd.loadOut;
      if (cmd.loadOut) dataOut <= shiftReg;
    end
  end

  p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt <= CNT_W'(WORD_W));

  p_shift_on_rise_r3: assert property (@(posedge clk) disable iff (!rstN)
    (bitCnt != $past(bitCnt) && bitCnt != '0) |-> $past(evt.sclRise));

endmodule

// File: rtl/wo_i2c_ctrl.sv
module wo_i2c_ctrl
  import wo_i2c_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  busEvt_t   evt,
  output dpCmd_t    cmd,
  output slvState_t stateOut
);

  slvState_t state, stateNext;

  always_comb begin
    stateNext    = state;
    cmd          = '0;
    cmd.shiftBit = ((state == ST_ADDR) || (state == ST_DATA)) && evt.sclRise && !evt.byteFull;
    if (evt.stopDet) begin
      stateNext    = ST_IDLE;
      cmd.ackOff   = 1'b1;
      cmd.clrCount = 1'b1;
      cmd.shiftBit = 1'b0;
    end else if (evt.startDet) begin
      stateNext    = ST_ADDR;
      cmd.ackOff   = 1'b1;
      cmd.clrCount = 1'b1;
      cmd.shiftBit = 1'b0;
    end else begin
      unique case (state)
        ST_ADDR: if (evt.sclFall && evt.byteFull) begin
          cmd.clrCount = 1'b1;
          if (evt.addrHit) begin
            stateNext = ST_ACK_A;
            cmd.ackOn = 1'b1;
          end else begin
            stateNext = ST_SKIP;
          end
        end
        ST_ACK_A: if (evt.sclFall) begin
          stateNext  = ST_DATA;
          cmd.ackOff = 1'b1;
        end
        ST_DATA: if (evt.sclFall && evt.byteFull) begin
          stateNext    = ST_ACK_D;
          cmd.ackOn    = 1'b1;
          cmd.loadOut  = 1'b1;
          cmd.clrCount = 1'b1;
        end
        ST_ACK_D: if (evt.sclFall) begin
          stateNext  = ST_SKIP;
          cmd.ackOff = 1'b1;
        end
        default: stateNext = state;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign stateOut = state;

  p_reject_goes_skip_r4: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ADDR && evt.sclFall && evt.byteFull && !evt.addrHit
     && !evt.startDet && !evt.stopDet) |=> (state == ST_SKIP));

  p_skip_holds_r7: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SKIP && !evt.startDet && !evt.stopDet) |=> (state == ST_SKIP));

endmodule

// File: rtl/wo_i2c_slave.sv
module wo_i2c_slave
  import wo_i2c_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'b1100000,
  parameter int         SYNC_STAGES = 2,
  parameter int         FILT_LEN    = 3
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  output logic       sdaOe,
  output logic [7:0] dataOut,
  output logic       dataValid
);

  localparam int ADDR_W = 7;
  localparam int WORD_W = ADDR_W + 1;
  localparam int CNT_W  = $clog2(WORD_W + 1);

  dpCmd_t           cmd;
  busEvt_t          evt;
  slvState_t        state;
  logic [CNT_W-1:0] bitCnt;

  wo_i2c_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .evt     (evt),
    .cmd     (cmd),
    .stateOut(state)
  );

  wo_i2c_datapath #(
    .ADDR_W     (ADDR_W),
    .WORD_W     (WORD_W),
    .DEV_ADDR   (DEV_ADDR),
    .SYNC_STAGES(SYNC_STAGES),
    .FILT_LEN   (FILT_LEN)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .sclIn    (sclIn),
    .sdaIn    (sdaIn),
    .cmd      (cmd),
    .evt      (evt),
    .sdaOe    (sdaOe),
    .dataOut  (dataOut),
    .dataValid(dataValid),
    .bitCnt   (bitCnt)
  );

  p_valid_pulse_r6: assert property (@(posedge clk) disable iff (!rstN)
    dataValid |=> !dataValid);

  p_valid_with_ack_r6: assert property (@(posedge clk) disable iff (!rstN)
    dataValid |-> sdaOe);

  p_oe_in_ack_r5: assert property (@(posedge clk) disable iff (!rstN)
    sdaOe |-> (state == ST_ACK_A || state == ST_ACK_D));

  p_oe_moves_on_fall_r5: assert property (@(posedge clk) disable iff (!rstN)
    (sdaOe != $past(sdaOe)) |-> $past(evt.sclFall || evt.startDet || evt.stopDet));

  p_start_restarts_r8: assert property (@(posedge clk) disable iff (!rstN)
    (evt.startDet && !evt.stopDet) |=> (state == ST_ADDR && bitCnt == '0));

  p_stop_idles_r9: assert property (@(posedge clk) disable iff (!rstN)
    evt.stopDet |=> (state == ST_IDLE && !sdaOe));

endmodule

// File: tb/wo_i2c_slave_bench.sv
module wo_i2c_slave_bench;

  localparam int T = 25;
  localparam logic [6:0] OWN_ADDR = 7'b1100000;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rstN = 1'b0;
  logic       sclM = 1'b1;
  logic       sdaM = 1'b1;
  logic       sdaOe;
  logic [7:0] dataOut;
  logic       dataValid;
  logic       sdaBus;

  assign sdaBus = sdaM & ~sdaOe;

  wo_i2c_slave u_wo_i2c_slave (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaBus),
    .sdaOe(sdaOe), .dataOut(dataOut), .dataValid(dataValid)
  );

  int checks = 0;
  int errors = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // behavioural reference model driven by raw bus events
  int         mState = 0;   // 0 idle 1 addr 2 ackA 3 data 4 ackD 5 skip
  int         mCnt = 0;
  logic [7:0] mShift = '0;
  bit         expOe = 1'b0;
  int         expValid = 0;
  logic [7:0] expData = 8'h00;

  function automatic void modelStart();
    mState = 1; mCnt = 0; expOe = 1'b0;
  endfunction
  function automatic void modelStop();
    mState = 0; mCnt = 0; expOe = 1'b0;
  endfunction
  function automatic void modelRise(input bit b);
    if ((mState == 1 || mState == 3) && mCnt < 8) begin
      mShift = {mShift[6:0], b};
      mCnt++;
    end
  endfunction
  function automatic void modelFall();
    if (mState == 1 && mCnt == 8) begin
      mCnt = 0;
      if (mShift == {OWN_ADDR, 1'b0}) begin mState = 2; expOe = 1'b1; end
      else mState = 5;
    end else if (mState == 2) begin
      mState = 3; mCnt = 0; expOe = 1'b0;
    end else if (mState == 3 && mCnt == 8) begin
      mState = 4; mCnt = 0; expOe = 1'b1;
      expValid++; expData = mShift;
    end else if (mState == 4) begin
      mState = 5; expOe = 1'b0;
    end
  endfunction

  // settle tracking and per-half-period drive comparison (R5)
  int   quiet = 0;
  logic pScl = 1'b1, pSda = 1'b1;
  always @(posedge clk) begin
    if (sclM != pScl || sdaM != pSda) quiet <= 0;
    else quiet <= quiet + 1;
    pScl <= sclM;
    pSda <= sdaM;
  end
  always @(negedge clk) begin
    if (rstN && quiet == 12) chk(sdaOe == expOe, "R5 sdaOe vs model", sdaOe, expOe);
  end

  // output strobe monitor (R6)
  int         validSeen = 0;
  logic [7:0] seenData = 8'h00;
  bit         prevValid = 1'b0;
  always @(negedge clk) begin
    if (rstN) begin
      if (dataValid) begin
        validSeen++;
        seenData = dataOut;
        chk(!prevValid, "R6 valid one cycle", 1, 0);
      end
      prevValid = dataValid;
    end
  end

  task automatic hp(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic busStart();
    sdaM = 1'b1; hp(T);
    sclM = 1'b1; hp(T);
    sdaM = 1'b0; modelStart(); hp(T);
    sclM = 1'b0; modelFall(); hp(4);
  endtask

  task automatic busStop();
    sdaM = 1'b0; hp(T);
    sclM = 1'b1; hp(T);
    sdaM = 1'b1; modelStop(); hp(T);
  endtask

  task automatic bitCycle(input bit b, input bit gl, output bit seen);
    sdaM = b;
    hp(8);
    if (gl) begin
      sclM = 1'b1; hp(2); sclM = 1'b0; hp(T - 10);
    end else begin
      hp(T - 8);
    end
    sclM = 1'b1; modelRise(b);
    hp(T / 2);
    seen = sdaBus;
    hp(T - T / 2);
    sclM = 1'b0; modelFall(); hp(4);
  endtask

  task automatic sendByte(input logic [7:0] b, input int glitchAt, output bit acked);
    bit s;
    for (int i = 7; i >= 0; i--) bitCycle(b[i], glitchAt == i, s);
    bitCycle(1'b1, 1'b0, s);
    acked = !s;
  endtask

  task automatic checkOut(input string req, input logic [7:0] wantData, input int wantCount);
    hp(T);
    chk(dataOut == wantData, req, dataOut, wantData);
    chk(dataOut == expData, {req, " model data"}, dataOut, expData);
    chk(validSeen == wantCount && validSeen == expValid, {req, " valid count"}, validSeen, wantCount);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    bit a, d;
    hp(5);
    // R1: reset state
    chk(sdaOe == 1'b0, "R1 sdaOe in reset", sdaOe, 0);
    chk(dataValid == 1'b0, "R1 valid in reset", dataValid, 0);
    chk(dataOut == 8'h00, "R1 data in reset", dataOut, 0);
    rstN = 1'b1;
    hp(20);
    chk(sdaOe == 1'b0 && dataValid == 1'b0 && dataOut == 8'h00, "R1 after reset", dataOut, 0);

    // R2: byte clocked with no START
    sclM = 1'b0; hp(T);
    sendByte({OWN_ADDR, 1'b0}, -1, a);
    chk(!a, "R2 no ack without start", a, 0);
    sendByte(8'h77, -1, d);
    busStop();
    checkOut("R2 no update", 8'h00, 0);

    // R3 + R6: good write, MSB first
    busStart();
    sendByte({OWN_ADDR, 1'b0}, -1, a);
    chk(a, "R3 address ack", a, 1);
    sendByte(8'hC4, -1, d);
    chk(d, "R6 data ack", d, 1);
    busStop();
    checkOut("R6 data C4", 8'hC4, 1);
    chk(seenData == 8'hC4, "R6 strobed data", seenData, 8'hC4);

    // R4: read request
    busStart();
    sendByte({OWN_ADDR, 1'b1}, -1, a);
    chk(!a, "R4 read nack", a, 0);
    sendByte(8'h11, -1, d);
    chk(!d, "R4 no data ack after read", d, 0);
    busStop();
    checkOut("R4 read no update", 8'hC4, 1);

    // R4: wrong address
    busStart();
    sendByte({7'b1100001, 1'b0}, -1, a);
    chk(!a, "R4 wrong address nack", a, 0);
    busStop();
    checkOut("R4 wrong address no update", 8'hC4, 1);

    // R7: extra byte
    busStart();
    sendByte({OWN_ADDR, 1'b0}, -1, a);
    chk(a, "R3 address ack 2", a, 1);
    sendByte(8'h12, -1, d);
    chk(d, "R6 data ack 2", d, 1);
    sendByte(8'hFF, -1, d);
    chk(!d, "R7 extra byte nack", d, 0);
    busStop();
    checkOut("R7 extra ignored", 8'h12, 2);

    // R8: repeated START mid address byte
    busStart();
    bitCycle(1'b1, 1'b0, a); bitCycle(1'b1, 1'b0, a);
    bitCycle(1'b0, 1'b0, a); bitCycle(1'b0, 1'b0, a);
    busStart();
    sendByte({OWN_ADDR, 1'b0}, -1, a);
    chk(a, "R8 ack after restart", a, 1);
    sendByte(8'h5A, -1, d);
    chk(d, "R8 data ack after restart", d, 1);
    busStop();
    checkOut("R8 restart data", 8'h5A, 3);

    // R9: STOP mid data byte
    busStart();
    sendByte({OWN_ADDR, 1'b0}, -1, a);
    chk(a, "R9 address ack", a, 1);
    bitCycle(1'b0, 1'b0, a); bitCycle(1'b1, 1'b0, a);
    bitCycle(1'b1, 1'b0, a); bitCycle(1'b0, 1'b0, a);
    busStop();
    chk(sdaOe == 1'b0, "R9 released after stop", sdaOe, 0);
    checkOut("R9 partial dropped", 8'h5A, 3);

    // R10: short SCL spike inside a data bit
    busStart();
    sendByte({OWN_ADDR, 1'b0}, -1, a);
    chk(a, "R10 address ack", a, 1);
    sendByte(8'h81, 3, d);
    chk(d, "R10 data ack with spike", d, 1);
    busStop();
    checkOut("R10 spike ignored", 8'h81, 4);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule